// File: doc/BRIEF.md
# ROM Data Patch Register Unit

This block sits between a read-only program/data memory and the processor read bus. It holds a small table of programmable address/data pairs. On every read, the bus address is compared against each enabled table slot. When a slot matches, the stored byte goes onto the read bus instead of the memory byte. Code or constants already fixed in the memory can therefore be corrected in the field without changing the memory itself.

The table is filled through a plain one-cycle register write port. A write selects a slot by index and loads that slot's target address, replacement byte and enable bit together. Any firmware routine or communication peripheral that can drive this port can install a patch. The substitution path is purely combinational. A patched read therefore has the same latency as an unpatched one, and the bus timing does not change.

Top module: `rom_patch_unit`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, every slot is disabled: each read returns `rom_rdata` unchanged and `patch_hit` stays low.
- R2: During a read (`rd_valid` high), if `rd_addr` equals the address of an enabled slot, `bus_rdata` carries that slot's byte in the same cycle, with no added register stage.
- R3: When no enabled slot matches the read address, `bus_rdata` equals `rom_rdata`.
- R4: A slot whose enable bit is 0 never matches, whatever address it holds.
- R5: If several enabled slots hold the read address, the slot with the lowest index supplies the byte.
- R6: A write with `cfg_we` high loads address, byte and enable into slot `cfg_idx` on the rising clock edge. The new contents act from the next cycle on, not before that edge. A write whose `cfg_idx` is 6 or 7 changes no slot.
- R7: `patch_hit` is high exactly when `rd_valid` is high and an enabled slot matches. With `rd_valid` low, no substitution happens and `bus_rdata` equals `rom_rdata`.
- R8: The six slots (indices 0 to 5) are independent. Six different addresses can be patched at the same time, each with its own byte.
- R9: Rewriting a slot replaces its previous contents completely. The old address no longer matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all slot enables |
| cfg_we | input | 1 | Slot write strobe |
| cfg_idx | input | 3 | Index of the slot to write (0 to 5 valid) |
| cfg_addr | input | 16 | Target address to store in the slot |
| cfg_data | input | 8 | Replacement byte to store in the slot |
| cfg_en | input | 1 | Enable bit to store in the slot |
| rd_valid | input | 1 | A read is in progress on the bus |
| rd_addr | input | 16 | Read address on the bus |
| rom_rdata | input | 8 | Byte returned by the memory for `rd_addr` |
| bus_rdata | output | 8 | Byte delivered to the processor |
| patch_hit | output | 1 | High during a read whose byte was substituted |

## Verification
The embedded properties check the following on every cycle:
- when `patch_hit` is low, the bus carries the memory byte;
- `patch_hit` never rises without a read;
- at most one slot is granted;
- the grant always falls on a slot that actually matched;
- out-of-range writes leave the enables untouched.

Only the directed scenarios can show the rest:
- that the right byte is chosen among several matching slots;
- that a disabled slot is ignored;
- that a write takes effect exactly one edge later;
- that a rewritten slot forgets its old address.

// File: rtl/patch_pkg.sv
package patch_pkg;
  localparam int unsigned PATCH_SLOTS_DEF = 6;
  localparam int unsigned PATCH_AW_DEF    = 16;
  localparam int unsigned PATCH_DW_DEF    = 8;

  // width of an index able to name n slots
  function automatic int unsigned slot_idx_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/patch_slot_bank.sv
module patch_slot_bank
  import patch_pkg::*;
#(
  parameter int unsigned SLOTS = PATCH_SLOTS_DEF,
  parameter int unsigned AW    = PATCH_AW_DEF,
  parameter int unsigned DW    = PATCH_DW_DEF,
  localparam int unsigned IW   = slot_idx_bits(SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [IW-1:0]        wr_idx,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 wr_en,
  output logic [SLOTS-1:0]     slot_en,
  output logic [SLOTS*AW-1:0]  slot_addr,
  output logic [SLOTS*DW-1:0]  slot_data
);
  logic [SLOTS-1:0] slot_sel;

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      assign slot_sel[g] = wr_stb && (wr_idx == IW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_en[g] <= 1'b0;
        end else if (slot_sel[g]) begin
          slot_en[g] <= wr_en;
        end
      end

      // address and byte need no reset: gated by slot_en
      always_ff @(posedge clk) begin
        if (slot_sel[g]) begin
          slot_addr[g*AW +: AW] <= wr_addr;
          slot_data[g*DW +: DW] <= wr_data;
        end
      end
    end
  endgenerate

  logic wr_out_of_range;
  assign wr_out_of_range = wr_stb && (slot_sel == '0);

  // R6
  oob_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out_of_range |=> $stable(slot_en));
endmodule

// File: rtl/patch_addr_match.sv
module patch_addr_match
  import patch_pkg::*;
#(
  parameter int unsigned SLOTS = PATCH_SLOTS_DEF,
  parameter int unsigned AW    = PATCH_AW_DEF
) (
  input  logic [AW-1:0]       look_addr,
  input  logic [SLOTS-1:0]    slot_en,
  input  logic [SLOTS*AW-1:0] slot_addr,
  output logic [SLOTS-1:0]    slot_hit
);
  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
      assign slot_hit[g] = slot_en[g] && (slot_addr[g*AW +: AW] == look_addr);
    end
  endgenerate
endmodule

// File: rtl/patch_prio_select.sv
module patch_prio_select
  import patch_pkg::*;
#(
  parameter int unsigned SLOTS = PATCH_SLOTS_DEF,
  parameter int unsigned DW    = PATCH_DW_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SLOTS-1:0]    slot_hit,
  input  logic [SLOTS*DW-1:0] slot_data,
  output logic [SLOTS-1:0]    grant,
  output logic                any_hit,
  output logic [DW-1:0]       patch_byte
);
  // isolate the lowest set bit of a request vector
  function automatic logic [SLOTS-1:0] lowest_one(input logic [SLOTS-1:0] req);
    logic [SLOTS-1:0] res;
    logic             seen;
    res  = '0;
    seen = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (req[i] && !seen) begin
        res[i] = 1'b1;
        seen   = 1'b1;
      end
    end
    return res;
  endfunction

  assign grant   = lowest_one(slot_hit);
  assign any_hit = |slot_hit;

  always_comb begin
    patch_byte = '0;
    for (int i = 0; i < SLOTS; i++) begin
      patch_byte = patch_byte | ({DW{grant[i]}} & slot_data[i*DW +: DW]);
    end
  end

  // R5
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R5
  grant_from_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~slot_hit) == '0);
endmodule

// File: rtl/rom_patch_unit.sv
module rom_patch_unit
  import patch_pkg::*;
#(
  parameter int unsigned SLOTS = PATCH_SLOTS_DEF,
  parameter int unsigned AW    = PATCH_AW_DEF,
  parameter int unsigned DW    = PATCH_DW_DEF,
  localparam int unsigned IW   = slot_idx_bits(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_data,
  input  logic          cfg_en,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rom_rdata,
  output logic [DW-1:0] bus_rdata,
  output logic          patch_hit
);
  logic [SLOTS-1:0]    slot_en;
  logic [SLOTS*AW-1:0] slot_addr;
  logic [SLOTS*DW-1:0] slot_data;
  logic [SLOTS-1:0]    slot_hit;
  logic [SLOTS-1:0]    grant;
  logic                any_hit;
  logic [DW-1:0]       patch_byte;

  patch_slot_bank #(.SLOTS(SLOTS), .AW(AW), .DW(DW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (cfg_we),
    .wr_idx    (cfg_idx),
    .wr_addr   (cfg_addr),
    .wr_data   (cfg_data),
    .wr_en     (cfg_en),
    .slot_en   (slot_en),
    .slot_addr (slot_addr),
    .slot_data (slot_data)
  );

  patch_addr_match #(.SLOTS(SLOTS), .AW(AW)) u_match (
    .look_addr (rd_addr),
    .slot_en   (slot_en),
    .slot_addr (slot_addr),
    .slot_hit  (slot_hit)
  );

  patch_prio_select #(.SLOTS(SLOTS), .DW(DW)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_hit   (slot_hit),
    .slot_data  (slot_data),
    .grant      (grant),
    .any_hit    (any_hit),
    .patch_byte (patch_byte)
  );

  assign patch_hit = rd_valid && any_hit;
  assign bus_rdata = patch_hit ? patch_byte : rom_rdata;

  // R3
  rom_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !patch_hit |-> (bus_rdata == rom_rdata));
  // R7
  hit_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    patch_hit |-> rd_valid);
  // R2
  hit_has_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    patch_hit |-> $countones(grant) == 1);
endmodule

// File: tb/test_rom_patch_unit.sv
module test_rom_patch_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [15:0] cfg_addr;
  logic [7:0]  cfg_data;
  logic        cfg_en;
  logic        rd_valid;
  logic [15:0] rd_addr;
  logic [7:0]  rom_rdata;
  logic [7:0]  bus_rdata;
  logic        patch_hit;

  logic [15:0] m_addr [NS];
  logic [7:0]  m_data [NS];
  logic        m_en   [NS];

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  assign rom_rdata = rom_byte(rd_addr);

  rom_patch_unit i_rom_patch_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_en(cfg_en),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rom_rdata(rom_rdata),
    .bus_rdata(bus_rdata), .patch_hit(patch_hit)
  );

  task automatic model_clear();
    for (int i = 0; i < NS; i++) m_en[i] = 1'b0;
  endtask

  // expected read result from the bench's own table
  task automatic expect_read(input logic [15:0] a, input logic v,
                             output logic [7:0] ed, output logic eh);
    ed = rom_byte(a);
    eh = 1'b0;
    if (v) begin
      for (int i = NS - 1; i >= 0; i--) begin
        if (m_en[i] && m_addr[i] == a) begin
          ed = m_data[i];
          eh = 1'b1;
        end
      end
    end
  endtask

  task automatic check_read(input logic [15:0] a, input logic v, input string req);
    logic [7:0] ed;
    logic eh;
    @(negedge clk);
    rd_addr  = a;
    rd_valid = v;
    #1;
    expect_read(a, v, ed, eh);
    n_vec++;
    if (bus_rdata !== ed || patch_hit !== eh) begin
      n_bad++;
      $display("FAIL %s addr=%h: got data=%h hit=%b, expected data=%h hit=%b",
               req, a, bus_rdata, patch_hit, ed, eh);
    end
  endtask

  task automatic write_slot(input logic [2:0] idx, input logic [15:0] a,
                            input logic [7:0] d, input logic en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_addr = a; cfg_data = d; cfg_en = en;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    if (idx < NS) begin
      m_addr[idx] = a; m_data[idx] = d; m_en[idx] = en;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R1
  task automatic t_reset_state();
    rst_n = 1'b0;
    check_read(16'h0000, 1'b1, "R1");
    check_read(16'h1234, 1'b1, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    check_read(16'hFFFF, 1'b1, "R1");
  endtask

  // R2 R3 R6
  task automatic t_single_patch();
    logic [7:0] ed;
    logic eh;
    // write staged but edge not yet reached: no effect (R6)
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd0; cfg_addr = 16'h1234; cfg_data = 8'hA5; cfg_en = 1'b1;
    rd_addr = 16'h1234; rd_valid = 1'b1;
    #1;
    expect_read(16'h1234, 1'b1, ed, eh);
    n_vec++;
    if (bus_rdata !== ed || patch_hit !== eh) begin
      n_bad++;
      $display("FAIL R6 before edge: got %h/%b expected %h/%b", bus_rdata, patch_hit, ed, eh);
    end
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    m_addr[0] = 16'h1234; m_data[0] = 8'hA5; m_en[0] = 1'b1;
    check_read(16'h1234, 1'b1, "R2");
    check_read(16'h1235, 1'b1, "R3");
    check_read(16'h0234, 1'b1, "R3");
  endtask

  // R4
  task automatic t_disabled();
    write_slot(3'd1, 16'h2000, 8'h77, 1'b0);
    check_read(16'h2000, 1'b1, "R4");
    write_slot(3'd0, 16'h1234, 8'hA5, 1'b0);
    check_read(16'h1234, 1'b1, "R4");
  endtask

  // R5
  task automatic t_priority();
    write_slot(3'd4, 16'h3000, 8'h22, 1'b1);
    write_slot(3'd2, 16'h3000, 8'h11, 1'b1);
    check_read(16'h3000, 1'b1, "R5");
    write_slot(3'd5, 16'h3000, 8'h33, 1'b1);
    check_read(16'h3000, 1'b1, "R5");
    write_slot(3'd2, 16'h3000, 8'h11, 1'b0);
    check_read(16'h3000, 1'b1, "R5");
  endtask

  // R8
  task automatic t_all_slots();
    for (int i = 0; i < NS; i++)
      write_slot(3'(i), 16'h4000 + 16'(i * 3), 8'hC0 + 8'(i), 1'b1);
    for (int i = 0; i < NS; i++)
      check_read(16'h4000 + 16'(i * 3), 1'b1, "R8");
    check_read(16'h4001, 1'b1, "R8");
  endtask

  // R6
  task automatic t_out_of_range();
    write_slot(3'd6, 16'h5555, 8'h99, 1'b1);
    write_slot(3'd7, 16'h4003, 8'h98, 1'b1);
    check_read(16'h5555, 1'b1, "R6");
    check_read(16'h4003, 1'b1, "R6");
  endtask

  // R7
  task automatic t_no_read();
    check_read(16'h4006, 1'b0, "R7");
    check_read(16'h4006, 1'b1, "R7");
  endtask

  // R9
  task automatic t_rewrite();
    write_slot(3'd3, 16'h6789, 8'h3C, 1'b1);
    check_read(16'h4009, 1'b1, "R9");
    check_read(16'h6789, 1'b1, "R9");
  endtask

  // R1
  task automatic t_reset_again();
    do_reset();
    check_read(16'h6789, 1'b1, "R1");
    check_read(16'h4000, 1'b1, "R1");
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_addr = '0; cfg_data = '0;
    cfg_en = 1'b0; rd_valid = 1'b0; rd_addr = '0;
    for (int i = 0; i < NS; i++) begin
      m_addr[i] = '0; m_data[i] = '0; m_en[i] = 1'b0;
    end
    t_reset_state();
    t_single_patch();
    t_disabled();
    t_priority();
    t_all_slots();
    t_out_of_range();
    t_no_read();
    t_rewrite();
    t_reset_again();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule